// File: doc/BRIEF.md
# Chained Four-Channel Reload Timer

This block holds four independent 16-bit up-counters behind one small synchronous register port. Each channel has a reload value, a control word and a live count. A running channel advances either on a divided copy of the system clock (divide by 1, 64, 256 or 1024 with default parameters) or, for channels above the lowest, once for every wrap of the channel directly beneath it. Chaining channels this way builds counters of 32, 48 or 64 bits.

When a count passes its top value, the channel restarts from its reload value instead of from zero. It can also flag a one-clock interrupt request on its own output line. Software loads a reload value, then sets the start bit. The counter takes the reload value only on the rising edge of that bit, or on a later wrap. Changing the tick rate keeps the whole count but throws away partial progress toward the next tick.

Top module: `reload_timer_bank`

## Requirements
- R1: After reset every counter, reload value and control word is zero. All interrupt lines are low and the read data is zero, so no channel runs.
- R2: Writing a channel's reload value leaves its running count unchanged. The new value takes effect only at the next start or wrap.
- R3: When an advancing count is at 0xFFFF, the next value is the channel's reload value, not zero.
- R4: Control bits [1:0] set the tick rate of a channel that is not chained. 0 gives one step per clock. 1, 2 and 3 give one step every 2^PS_LOG1, 2^PS_LOG2 and 2^PS_LOG3 clocks.
- R5: On channels 1 to 3, control bit 2 chains the channel to the one below. The channel then steps exactly once in the same clock cycle as each wrap of that lower channel, and the rate bits are ignored.
- R6: On channel 0, control bit 2 is stored and read back but does not affect counting. The rate bits stay in force.
- R7: When control bit 6 is set, each wrap of a channel drives its irq bit high for exactly the one cycle after the wrapping edge. When bit 6 is clear, irq stays low.
- R8: Control bit 7 runs the channel. A write that takes bit 7 from 0 to 1 loads the count from the reload value and clears prescaler progress. Writing 1 when it is already 1 does not reload. With bit 7 at 0 the count holds.
- R9: Only control bits 7, 6, 2, 1 and 0 are stored. Every other control bit reads as 0.
- R10: Any write to the low control byte keeps the current count and restarts the prescaler from zero progress.
- R11: addr[2:1] picks the channel. With addr[0]=0 a write goes to the reload value and a read returns the live count. With addr[0]=1 it is the control word. rdata is registered and shows the register addressed in the previous cycle.
- R12: wstrb[0] enables writing bits 7:0 and wstrb[1] enables bits 15:8. A write with both strobes clear changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write request this cycle |
| addr | input | 3 | {channel, register select} |
| wdata | input | 16 | Write data |
| wstrb | input | 2 | Byte-lane write enables |
| rdata | output | 16 | Registered read data |
| irq | output | 4 | Per-channel wrap interrupt pulses |

## Verification
The bench builds the block with PS_LOG1=2, PS_LOG2=3 and PS_LOG3=4, so the divide-by-4, 8 and 16 rates cycle many times in a short run. Dropping partial progress mid-period and all three rate settings can therefore be compared cycle by cycle. Reload values near 0xFFFF make wraps frequent. This lets a chained channel wrap too, so two wraps land in one cycle. Counter width and channel count stay at their defaults.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;
  localparam int REG_W   = 16;
  localparam int NBYTES  = REG_W / 8;
  localparam logic [REG_W-1:0] CTL_MASK = 16'h00C7;

  typedef struct packed {
    logic       en;
    logic       ie;
    logic       casc;
    logic [1:0] ps;
  } tctl_t;

  function automatic logic [REG_W-1:0] ctl_to_word(tctl_t c);
    return {8'h00, c.en, c.ie, 3'b000, c.casc, c.ps};
  endfunction

  function automatic tctl_t byte_to_ctl(logic [7:0] b);
    tctl_t c;
    c.en   = b[7];
    c.ie   = b[6];
    c.casc = b[2];
    c.ps   = b[1:0];
    return c;
  endfunction
endpackage

// File: rtl/rtimer_prescale.sv
module rtimer_prescale #(
  parameter int LOG1 = 6,
  parameter int LOG2 = 8,
  parameter int LOG3 = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       clr,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int PW = LOG3;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim;

  always_comb begin
    case (sel)
      2'd0:    lim = '0;
      2'd1:    lim = PW'((32'd1 << LOG1) - 32'd1);
      2'd2:    lim = PW'((32'd1 << LOG2) - 32'd1);
      default: lim = PW'((32'd1 << LOG3) - 32'd1);
    endcase
  end

  assign tick = run && (pre_q == lim);

  always_ff @(posedge clk) begin
    if (rst)       pre_q <= '0;
    else if (clr)  pre_q <= '0;
    else if (run)  pre_q <= (pre_q == lim) ? '0 : pre_q + 1'b1;
  end

  // R4: fractional progress never exceeds the period of the selected rate
  p_pre_bound_r4: assert property (@(posedge clk) disable iff (rst) pre_q <= lim);
endmodule

// File: rtl/rtimer_channel.sv
module rtimer_channel
  import rtimer_pkg::*;
#(
  parameter int LOG1  = 6,
  parameter int LOG2  = 8,
  parameter int LOG3  = 10,
  parameter bit FIRST = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_rel,
  input  logic              wr_ctl,
  input  logic [NBYTES-1:0] wstrb,
  input  logic [REG_W-1:0]  wdata,
  input  logic              casc_in,
  output logic              ovf,
  output logic [REG_W-1:0]  cnt,
  output logic [REG_W-1:0]  ctl_word,
  output logic              irq
);
  logic [REG_W-1:0] cnt_q, rel_q, rel_d;
  tctl_t            ctl_q, ctl_new;
  logic             irq_q;
  logic             ctl_lo_wr, start, casc_eff, pre_tick, adv;

  assign ctl_lo_wr = wr_ctl && wstrb[0];
  assign ctl_new   = byte_to_ctl(wdata[7:0]);
  assign start     = ctl_lo_wr && !ctl_q.en && ctl_new.en;

  generate
    if (FIRST) begin : g_base
      assign casc_eff = 1'b0;
    end else begin : g_chain
      assign casc_eff = ctl_q.casc;
    end
  endgenerate

  rtimer_prescale #(.LOG1(LOG1), .LOG2(LOG2), .LOG3(LOG3)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (ctl_q.en && !casc_eff),
    .clr  (ctl_lo_wr),
    .sel  (ctl_q.ps),
    .tick (pre_tick)
  );

  assign adv = ctl_q.en && (casc_eff ? casc_in : pre_tick);
  assign ovf = adv && (cnt_q == {REG_W{1'b1}});

  always_comb begin
    rel_d = rel_q;
    for (int b = 0; b < NBYTES; b++) begin
      if (wr_rel && wstrb[b]) rel_d[8*b +: 8] = wdata[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rel_q <= '0;
      ctl_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (start)     cnt_q <= rel_q;
      else if (ovf)  cnt_q <= rel_q;
      else if (adv)  cnt_q <= cnt_q + 1'b1;
      rel_q <= rel_d;
      if (ctl_lo_wr) ctl_q <= ctl_new;
      irq_q <= ovf && ctl_q.ie;
    end
  end

  assign cnt      = cnt_q;
  assign ctl_word = ctl_to_word(ctl_q);
  assign irq      = irq_q;

  // R3: a wrap restarts the count from the reload value held before the edge
  p_wrap_reload_r3: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (cnt_q == $past(rel_q)));
  // R8: a start edge preloads the count
  p_start_load_r8: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt_q == $past(rel_q)));
  // R8: a stopped channel holds its count unless it is started
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q.en && !start) |=> $stable(cnt_q));
  // R5: a chained channel moves only when the lower channel wraps
  p_casc_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.en && casc_eff && !casc_in) |=> $stable(cnt_q));
endmodule

// File: rtl/rtimer_regif.sv
module rtimer_regif
  import rtimer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CHW    = 2,
  parameter int AW     = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [AW-1:0]                addr,
  input  logic [NUM_CH-1:0][REG_W-1:0] cnt_v,
  input  logic [NUM_CH-1:0][REG_W-1:0] ctl_v,
  output logic [NUM_CH-1:0]            wr_rel,
  output logic [NUM_CH-1:0]            wr_ctl,
  output logic [REG_W-1:0]             rdata
);
  logic [CHW-1:0]   ch;
  logic             sel_ctl;
  logic [REG_W-1:0] rdata_q;
  logic             rd_ctl_q;

  assign ch      = addr[AW-1:1];
  assign sel_ctl = addr[0];

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
      assign wr_rel[i] = wr_en && (ch == CHW'(i)) && !sel_ctl;
      assign wr_ctl[i] = wr_en && (ch == CHW'(i)) &&  sel_ctl;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rd_ctl_q <= 1'b0;
    end else begin
      rdata_q  <= sel_ctl ? ctl_v[ch] : cnt_v[ch];
      rd_ctl_q <= sel_ctl;
    end
  end

  assign rdata = rdata_q;

  // R11: a single write reaches at most one register
  p_single_target_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_rel, wr_ctl}));
  // R9: unstored control bits always read back as zero
  p_ctl_rsvd_zero_r9: assert property (@(posedge clk) disable iff (rst)
    rd_ctl_q |-> ((rdata_q & ~CTL_MASK) == '0));
endmodule

// File: rtl/reload_timer_bank.sv
module reload_timer_bank
  import rtimer_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int PS_LOG1 = 6,
  parameter int PS_LOG2 = 8,
  parameter int PS_LOG3 = 10,
  localparam int CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int AW     = CHW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [NBYTES-1:0] wstrb,
  output logic [REG_W-1:0]  rdata,
  output logic [NUM_CH-1:0] irq
);
  logic [NUM_CH-1:0]            wr_rel, wr_ctl, ovf;
  logic [NUM_CH-1:0][REG_W-1:0] cnt_v, ctl_v;

  rtimer_regif #(.NUM_CH(NUM_CH), .CHW(CHW), .AW(AW)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .addr   (addr),
    .cnt_v  (cnt_v),
    .ctl_v  (ctl_v),
    .wr_rel (wr_rel),
    .wr_ctl (wr_ctl),
    .rdata  (rdata)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic src;
      if (i == 0) begin : g_src0
        assign src = 1'b0;
      end else begin : g_srcn
        assign src = ovf[i-1];
      end

      rtimer_channel #(
        .LOG1(PS_LOG1), .LOG2(PS_LOG2), .LOG3(PS_LOG3), .FIRST(i == 0)
      ) u_ch (
        .clk      (clk),
        .rst      (rst),
        .wr_rel   (wr_rel[i]),
        .wr_ctl   (wr_ctl[i]),
        .wstrb    (wstrb),
        .wdata    (wdata),
        .casc_in  (src),
        .ovf      (ovf[i]),
        .cnt      (cnt_v[i]),
        .ctl_word (ctl_v[i]),
        .irq      (irq[i])
      );

      // R7: an interrupt pulse always follows a wrap of the same channel
      p_irq_after_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        irq[i] |-> $past(ovf[i]));
    end
  endgenerate
endmodule

// File: tb/reload_timer_bank_tb.sv
`timescale 1ns/1ps
module reload_timer_bank_tb;
  localparam int L1 = 2, L2 = 3, L3 = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  wstrb = '0;
  logic [15:0] rdata;
  logic [3:0]  irq;

  int checks = 0, failures = 0;
  string phase = "R1";
  bit done = 0;

  int m_cnt[4], m_rel[4], m_ctl[4], m_pre[4];
  logic [15:0] exp_rdata;
  logic [3:0]  exp_irq;

  always #10 clk = ~clk;

  reload_timer_bank #(.NUM_CH(4), .PS_LOG1(L1), .PS_LOG2(L2), .PS_LOG3(L3)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .wstrb(wstrb), .rdata(rdata), .irq(irq)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, one step per rising edge
  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 4; c++) begin
        m_cnt[c] = 0; m_rel[c] = 0; m_ctl[c] = 0; m_pre[c] = 0;
      end
      exp_rdata = '0;
      exp_irq   = '0;
    end else begin
      int ovf_prev, ch;
      logic [3:0] nirq;
      ch = int'(addr) / 2;
      exp_rdata = addr[0] ? 16'(m_ctl[ch]) : 16'(m_cnt[ch]);
      ovf_prev = 0;
      nirq = '0;
      for (int c = 0; c < 4; c++) begin
        int dv, ovf, adv;
        case (m_ctl[c] & 3)
          0: dv = 1;
          1: dv = 1 << L1;
          2: dv = 1 << L2;
          default: dv = 1 << L3;
        endcase
        adv = 0; ovf = 0;
        if ((m_ctl[c] & 'h80) != 0) begin
          if (c > 0 && (m_ctl[c] & 'h04) != 0) adv = ovf_prev;
          else if (m_pre[c] == dv - 1) begin adv = 1; m_pre[c] = 0; end
          else m_pre[c] = m_pre[c] + 1;
        end
        if (adv != 0) begin
          if (m_cnt[c] == 'hFFFF) begin m_cnt[c] = m_rel[c]; ovf = 1; end
          else m_cnt[c] = m_cnt[c] + 1;
        end
        nirq[c] = (ovf != 0) && ((m_ctl[c] & 'h40) != 0);
        ovf_prev = ovf;
      end
      if (wr_en) begin
        if (!addr[0]) begin
          if (wstrb[0]) m_rel[ch] = (m_rel[ch] & 'hFF00) | int'(wdata[7:0]);
          if (wstrb[1]) m_rel[ch] = (m_rel[ch] & 'h00FF) | (int'(wdata[15:8]) << 8);
        end else if (wstrb[0]) begin
          int nw;
          nw = int'(wdata) & 'hC7;
          if ((m_ctl[ch] & 'h80) == 0 && (nw & 'h80) != 0) m_cnt[ch] = m_rel[ch];
          m_ctl[ch] = nw;
          m_pre[ch] = 0;
        end
      end
      exp_irq = nirq;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({phase, " rdata"}, rdata, exp_rdata);
      chk({phase, " irq"}, {12'h000, irq}, {12'h000, exp_irq});
    end
  end

  task automatic wr(logic [2:0] a, logic [15:0] d, logic [1:0] s);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; wstrb = s;
    @(negedge clk);
    wr_en = 1'b0; wstrb = '0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #4000000;
    checks++; failures++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    run(3);
    rst = 1'b0;
    addr = 3'd1;
    run(2);
    chk("R1 ctl0 after reset", rdata, 16'h0000);
    chk("R1 irq after reset", {12'h0, irq}, 16'h0000);

    phase = "R12";
    wr(3'd0, 16'h00FC, 2'b01);
    wr(3'd0, 16'hFF00, 2'b10);
    wr(3'd0, 16'h1234, 2'b00);

    phase = "R8";
    wr(3'd1, 16'h00C0, 2'b01);
    addr = 3'd0;
    run(1);
    chk("R8 start preload", rdata, 16'hFFFC);
    run(11);

    phase = "R2";
    wr(3'd0, 16'hFFF0, 2'b11);
    run(2);
    phase = "R3";
    run(24);

    phase = "R8";
    wr(3'd1, 16'h00C0, 2'b01);
    run(6);

    phase = "R5";
    wr(3'd2, 16'hFFFE, 2'b11);
    wr(3'd3, 16'h00C4, 2'b01);
    addr = 3'd2;
    run(70);

    phase = "R7";
    wr(3'd4, 16'hFFF8, 2'b11);
    wr(3'd5, 16'h0080, 2'b01);
    addr = 3'd4;
    run(30);

    phase = "R4";
    wr(3'd5, 16'h00C1, 2'b01);
    run(50);
    wr(3'd5, 16'h00C2, 2'b01);
    run(80);
    wr(3'd5, 16'h00C3, 2'b01);
    run(150);

    phase = "R10";
    run(7);
    wr(3'd5, 16'h00C3, 2'b01);
    run(12);
    wr(3'd5, 16'h00C1, 2'b01);
    run(40);

    phase = "R6";
    wr(3'd1, 16'h00C5, 2'b01);
    addr = 3'd0;
    run(60);

    phase = "R9";
    wr(3'd6, 16'hFFFF, 2'b11);
    wr(3'd7, 16'hFFFF, 2'b11);
    addr = 3'd7;
    run(2);
    chk("R9 ctl3 readback", rdata, 16'h00C7);
    run(30);

    phase = "R11";
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a);
      run(3);
    end

    phase = "R8";
    wr(3'd1, 16'h0000, 2'b01);
    addr = 3'd0;
    run(2);
    begin
      logic [15:0] held;
      held = rdata;
      run(10);
      chk("R8 stopped count holds", rdata, held);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule